// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Victim Write Queue

The block is a direct-mapped data cache placed between a processor load/store port and a slower line-wide memory port. Each of its lines carries a valid flag, a dirty flag, a tag and a full line of data. Loads and stores that hit are served from the line array. A store that hits only marks the line dirty. Memory sees no traffic until the line is displaced.

On a miss, the line at the request's index is the victim. A dirty victim goes onto the tail of a small first-in first-out queue, and that queue drains to memory on its own through a separate write port. Before a refill is requested, the wanted line address is compared with every queued entry. On a match, the line is taken from the newest matching entry, so memory is never read while it still holds stale data. Store misses allocate: the line is filled first and the store is then merged into it. A separate invalidate operation drops the addressed line without writing it back.

Top module: `wbc_cache`

## Requirements
- R1: Address split: bits 4..2 select the 32-bit word in a 32-byte line, bits 10..5 are the line index and bits 31..11 the tag. Memory line addresses (`mem_rd_addr_o`, `mem_wr_addr_o`) are address bits 31..5. Word k of a line occupies bits 32k+31..32k of the line buses.
- R2: After reset every line is invalid, so the first access to any address misses. Out of reset `req_ready_o` is 1 and `rsp_valid_o`, `mem_rd_valid_o` and `mem_wr_valid_o` are 0.
- R3: A load that hits raises `rsp_valid_o` for one cycle in the cycle after acceptance, with the stored word, and issues no memory read.
- R4: A store that hits updates the cached word and sets the line dirty. It issues no memory read or write, and neither do repeated stores to the same line.
- R5: A load miss fetches the whole line with one read at the request's line address, replaces the victim and returns the requested word. `req_ready_o` stays 0 from acceptance until the response.
- R6: A store miss refills the line, merges the store word into it and marks the line dirty.
- R7: A dirty victim is appended to the write queue. The queue head is presented on the write port with valid, address and data held stable until `mem_wr_ready_i`. Entries leave in the order they entered.
- R8: The queue holds 4 entries. A miss whose victim is dirty waits, without responding, while the queue is full, and it completes once an entry drains.
- R9: A refill whose line address matches a queued entry takes the newest matching entry's data and issues no memory read. A memory read is never issued for a line still in the queue.
- R10: Invalidate (`req_inval_i` with `req_valid_i`) clears the indexed line's valid flag only when the tag matches, and discards its dirty data without a write-back. It responds in the next cycle. A non-matching invalidate leaves the line hitting.
- R11: A clean victim is dropped and never enters the write queue.
- R12: `mem_rd_valid_o` stays high with a stable address until `mem_rd_ready_i`. The refill line is taken in the cycle `mem_rdata_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_inval_i | input | 1 | Invalidate the addressed line instead of load/store |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store word |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 32 | Load word (store word on stores, 0 on invalidate) |
| mem_rd_valid_o | output | 1 | Line read request |
| mem_rd_ready_i | input | 1 | Memory accepts the read request |
| mem_rd_addr_o | output | 27 | Line address to read |
| mem_rdata_valid_i | input | 1 | Refill line present |
| mem_rdata_i | input | 256 | Refill line data |
| mem_wr_valid_o | output | 1 | Queue head write-back request |
| mem_wr_ready_i | input | 1 | Memory acknowledges the write |
| mem_wr_addr_o | output | 27 | Line address of the queue head |
| mem_wr_data_o | output | 256 | Line data of the queue head |

## Verification
The assertions take several things for granted about the environment. Memory returns exactly one refill beat, and only after it has accepted a read. The processor holds its request stable while `req_ready_o` is low. The stale-read and handshake-hold properties depend on memory never acknowledging a write that is not presented. The bench's memory responder returns data a fixed three cycles after each accepted read and acknowledges only presented writes. The processor driver holds each request until it is accepted and waits for the response before issuing the next one. Ready patterns are randomised on both memory ports, and the write port can be forced closed so that queue-full and forwarding cases are reached.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_LOOKUP,
    ST_FETCH_REQ,
    ST_FETCH_WAIT
  } wbc_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
  parameter int NUM_LINES = 64,
  parameter int TAG_W     = 21,
  parameter int LINE_W    = 256,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic              wr_dirty_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_data_i
);
  logic [NUM_LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    data_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  // a line is never dirty without being valid
  p_dirty_implies_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_dirty_i |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/wbc_wb_queue.sv
module wbc_wb_queue #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 27,
  parameter int DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              full_o,
  output logic              head_valid_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  assign full_o       = (cnt_q == CNT_W'(DEPTH));
  assign head_valid_o = (cnt_q != '0);
  assign head_addr_o  = addr_q[rd_ptr_q];
  assign head_data_o  = data_q[rd_ptr_q];

  // walk oldest to newest so the newest match wins
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int slot;
      slot = int'(rd_ptr_q) + i;
      if (slot >= DEPTH) slot = slot - DEPTH;
      if (i < int'(cnt_q) && addr_q[PTR_W'(slot)] == lk_addr_i) begin
        lk_hit_o  = 1'b1;
        lk_data_o = data_q[PTR_W'(slot)];
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o || pop_i);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int NUM_LINES  = 64,
  parameter int WQ_DEPTH   = 4,
  localparam int LINE_W    = DATA_W * LINE_WORDS,
  localparam int OFF_W     = $clog2(LINE_WORDS * (DATA_W / 8)),
  localparam int LADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic               req_inval_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               mem_rd_valid_o,
  input  logic               mem_rd_ready_i,
  output logic [LADDR_W-1:0] mem_rd_addr_o,
  input  logic               mem_rdata_valid_i,
  input  logic [LINE_W-1:0]  mem_rdata_i,
  output logic               mem_wr_valid_o,
  input  logic               mem_wr_ready_i,
  output logic [LADDR_W-1:0] mem_wr_addr_o,
  output logic [LINE_W-1:0]  mem_wr_data_o
);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int BOFF_W = OFF_W - WORD_W;
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  wbc_state_e state_q, state_d;
  logic [ADDR_W-1:0] sv_addr_q;
  logic              sv_we_q;
  logic [DATA_W-1:0] sv_wdata_q;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [WORD_W-1:0] cur_word;
  logic              accept, hit, do_fill;

  logic              ls_valid, ls_dirty;
  logic [TAG_W-1:0]  ls_tag;
  logic [LINE_W-1:0] ls_data;
  logic              ls_wr_en, ls_wr_valid, ls_wr_dirty;
  logic [LINE_W-1:0] ls_wr_data, fill_line;

  logic              q_push, q_pop, q_full, q_lk_hit;
  logic [LINE_W-1:0] q_lk_data;

  logic unused_bits;

  function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WORD_W-1:0] w);
    return ln[int'(w)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WORD_W-1:0] w,
                                                 input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] r;
    r = ln;
    r[int'(w)*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  assign cur_addr    = (state_q == ST_IDLE) ? req_addr_i : sv_addr_q;
  assign cur_idx     = cur_addr[OFF_W +: IDX_W];
  assign cur_tag     = cur_addr[ADDR_W-1 -: TAG_W];
  assign cur_word    = cur_addr[BOFF_W +: WORD_W];
  assign unused_bits = ^cur_addr[BOFF_W-1:0];

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = ls_valid && (ls_tag == cur_tag);
  assign fill_line   = (state_q == ST_LOOKUP) ? q_lk_data : mem_rdata_i;

  assign mem_rd_valid_o = (state_q == ST_FETCH_REQ);
  assign mem_rd_addr_o  = sv_addr_q[ADDR_W-1:OFF_W];
  assign q_pop          = mem_wr_valid_o && mem_wr_ready_i;

  always_comb begin
    state_d     = state_q;
    ls_wr_en    = 1'b0;
    ls_wr_valid = 1'b1;
    ls_wr_dirty = 1'b0;
    ls_wr_data  = ls_data;
    q_push      = 1'b0;
    do_fill     = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_rdata_d = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_inval_i) begin
            rsp_valid_d = 1'b1;
            if (hit) begin
              ls_wr_en    = 1'b1;
              ls_wr_valid = 1'b0;
            end
          end else if (hit) begin
            rsp_valid_d = 1'b1;
            rsp_rdata_d = get_word(ls_data, cur_word);
            if (req_write_i) begin
              ls_wr_en    = 1'b1;
              ls_wr_dirty = 1'b1;
              ls_wr_data  = put_word(ls_data, cur_word, req_wdata_i);
              rsp_rdata_d = req_wdata_i;
            end
          end else begin
            state_d = ST_EVICT;
          end
        end
      end
      ST_EVICT: begin
        if (ls_valid && ls_dirty) begin
          if (!q_full) begin
            q_push  = 1'b1;
            state_d = ST_LOOKUP;
          end
        end else begin
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (q_lk_hit) do_fill = 1'b1;
        else          state_d = ST_FETCH_REQ;
      end
      ST_FETCH_REQ: begin
        if (mem_rd_ready_i) state_d = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: begin
        if (mem_rdata_valid_i) do_fill = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (do_fill) begin
      ls_wr_en    = 1'b1;
      ls_wr_dirty = sv_we_q;
      ls_wr_data  = sv_we_q ? put_word(fill_line, cur_word, sv_wdata_q) : fill_line;
      rsp_valid_d = 1'b1;
      rsp_rdata_d = get_word(ls_wr_data, cur_word);
      state_d     = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sv_addr_q   <= '0;
      sv_we_q     <= 1'b0;
      sv_wdata_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_rdata_q <= rsp_rdata_d;
      if (accept) begin
        sv_addr_q  <= req_addr_i;
        sv_we_q    <= req_write_i;
        sv_wdata_q <= req_wdata_i;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  wbc_line_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (cur_idx),
    .rd_valid_o (ls_valid),
    .rd_dirty_o (ls_dirty),
    .rd_tag_o   (ls_tag),
    .rd_data_o  (ls_data),
    .wr_en_i    (ls_wr_en),
    .wr_idx_i   (cur_idx),
    .wr_valid_i (ls_wr_valid),
    .wr_dirty_i (ls_wr_dirty),
    .wr_tag_i   (cur_tag),
    .wr_data_i  (ls_wr_data)
  );

  wbc_wb_queue #(
    .DEPTH(WQ_DEPTH), .ADDR_W(LADDR_W), .DATA_W(LINE_W)
  ) u_wbq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (q_push),
    .push_addr_i  ({ls_tag, cur_idx}),
    .push_data_i  (ls_data),
    .full_o       (q_full),
    .head_valid_o (mem_wr_valid_o),
    .head_addr_o  (mem_wr_addr_o),
    .head_data_o  (mem_wr_data_o),
    .pop_i        (q_pop),
    .lk_addr_i    (cur_addr[ADDR_W-1:OFF_W]),
    .lk_hit_o     (q_lk_hit),
    .lk_data_o    (q_lk_data)
  );

  p_hit_rsp_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !req_inval_i && hit |=> rsp_valid_o);
  p_rd_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));
  p_wr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && !mem_wr_ready_i |=>
      mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));
  p_no_stale_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !q_lk_hit);
  p_stall_on_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |-> !req_ready_o);
endmodule

// File: tb/wbc_cache_tb.sv
module wbc_cache_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         rst_ni;
  logic         req_valid_i, req_ready_o, req_write_i, req_inval_i;
  logic [31:0]  req_addr_i, req_wdata_i;
  logic         rsp_valid_o;
  logic [31:0]  rsp_rdata_o;
  logic         mem_rd_valid_o, mem_rd_ready_i;
  logic [26:0]  mem_rd_addr_o;
  logic         mem_rdata_valid_i;
  logic [255:0] mem_rdata_i;
  logic         mem_wr_valid_o, mem_wr_ready_i;
  logic [26:0]  mem_wr_addr_o;
  logic [255:0] mem_wr_data_o;

  wbc_cache u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_inval_i(req_inval_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_ready_i(mem_rd_ready_i),
    .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rdata_valid_i(mem_rdata_valid_i), .mem_rdata_i(mem_rdata_i),
    .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_ready_i(mem_wr_ready_i),
    .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit           m_valid [64];
  bit           m_dirty [64];
  int           m_tag   [64];
  logic [255:0] m_data  [64];
  int           wq_addr [$];
  logic [255:0] wq_data [$];
  logic [255:0] mem_a   [int];

  bit   wr_hold = 0, released = 0;
  int   rd_cnt = 0, rd_pend = 0, rd_line = 0, exp_line = 0;
  bit   prev_wr_wait = 0, prev_rd_wait = 0;
  logic [26:0] prev_wr_addr, prev_rd_addr;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] init_line(input int la);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = 32'(la * 8 + w) ^ 32'hC3A5_0000;
    return r;
  endfunction

  function automatic logic [255:0] mem_line(input int la);
    if (mem_a.exists(la)) return mem_a[la];
    return init_line(la);
  endfunction

  function automatic logic [255:0] backing(input int la);
    for (int i = wq_addr.size() - 1; i >= 0; i--)
      if (wq_addr[i] == la) return wq_data[i];
    return mem_line(la);
  endfunction

  function automatic bit in_queue(input int la);
    foreach (wq_addr[i]) if (wq_addr[i] == la) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mk(input int tg, input int idx, input int w);
    return {21'(tg), 6'(idx), 3'(w), 2'b00};
  endfunction

  task automatic model(input bit we, input bit inv, input logic [31:0] a,
                       input logic [31:0] wd, output bit ehit, output logic [31:0] erd);
    int idx, tg, w, la;
    idx = int'(a[10:5]); tg = int'(a[31:11]); w = int'(a[4:2]); la = int'(a[31:5]);
    erd = '0;
    if (inv) begin
      ehit = 1;
      if (m_valid[idx] && m_tag[idx] == tg) begin
        m_valid[idx] = 0;
        m_dirty[idx] = 0;
      end
      return;
    end
    ehit = m_valid[idx] && m_tag[idx] == tg;
    if (!ehit) begin
      if (m_valid[idx] && m_dirty[idx]) begin
        wq_addr.push_back(m_tag[idx] * 64 + idx);
        wq_data.push_back(m_data[idx]);
      end
      m_data[idx]  = backing(la);
      m_valid[idx] = 1;
      m_tag[idx]   = tg;
      m_dirty[idx] = 0;
    end
    if (we) begin
      m_data[idx][w*32 +: 32] = wd;
      m_dirty[idx] = 1;
    end
    erd = m_data[idx][w*32 +: 32];
  endtask

  // one clock: memory responder and port-protocol checks at the falling edge
  task automatic tick();
    bit nwr, nrd;
    @(negedge clk);
    if (prev_wr_wait)
      chk(mem_wr_valid_o && mem_wr_addr_o == prev_wr_addr, "R7 write head held",
          {mem_wr_valid_o, mem_wr_addr_o}, {1'b1, prev_wr_addr});
    nwr = wr_hold ? 1'b0 : ($urandom % 4 != 0);
    mem_wr_ready_i = nwr;
    if (mem_wr_valid_o && nwr) begin
      if (wq_addr.size() == 0) begin
        chk(0, "R7 unexpected write-back", 256'(mem_wr_addr_o), 0);
      end else begin
        chk(mem_wr_addr_o == 27'(wq_addr[0]), "R7 write-back order address",
            256'(mem_wr_addr_o), 256'(wq_addr[0]));
        chk(mem_wr_data_o == wq_data[0], "R7 write-back data", mem_wr_data_o, wq_data[0]);
        mem_a[wq_addr[0]] = wq_data[0];
        void'(wq_addr.pop_front());
        void'(wq_data.pop_front());
      end
    end
    prev_wr_wait = mem_wr_valid_o && !nwr;
    prev_wr_addr = mem_wr_addr_o;

    if (prev_rd_wait)
      chk(mem_rd_valid_o && mem_rd_addr_o == prev_rd_addr, "R12 read request held",
          {mem_rd_valid_o, mem_rd_addr_o}, {1'b1, prev_rd_addr});
    mem_rdata_valid_i = 1'b0;
    if (rd_pend > 0) begin
      rd_pend--;
      if (rd_pend == 0) begin
        mem_rdata_valid_i = 1'b1;
        mem_rdata_i = mem_line(rd_line);
      end
    end
    nrd = ($urandom % 3 != 0);
    mem_rd_ready_i = nrd;
    if (mem_rd_valid_o && nrd) begin
      rd_cnt++;
      rd_line = int'(mem_rd_addr_o);
      chk(rd_line == exp_line, "R1 refill line address", 256'(rd_line), 256'(exp_line));
      chk(!in_queue(rd_line), "R9 read of a queued line", 256'(rd_line), 0);
      rd_pend = 3;
    end
    prev_rd_wait = mem_rd_valid_o && !nrd;
    prev_rd_addr = mem_rd_addr_o;
  endtask

  task automatic do_req(input bit we, input bit inv, input logic [31:0] a,
                        input logic [31:0] wd, input string tg, input int release_at);
    bit ehit;
    logic [31:0] erd;
    int rd0, waited;
    req_valid_i = 1; req_write_i = we; req_inval_i = inv;
    req_addr_i = a; req_wdata_i = wd;
    while (!req_ready_o) tick();
    model(we, inv, a, wd, ehit, erd);
    exp_line = int'(a[31:5]);
    rd0 = rd_cnt;
    tick();
    req_valid_i = 0;
    if (ehit) chk(rsp_valid_o, {tg, " R3 response one cycle after hit"}, 256'(rsp_valid_o), 1);
    waited = 0;
    released = 0;
    while (!rsp_valid_o && waited < 3000) begin
      chk(!req_ready_o, {tg, " R5 ready low during miss"}, 256'(req_ready_o), 0);
      if (release_at > 0 && waited == release_at) begin
        released = 1;
        wr_hold = 0;
      end
      tick();
      waited++;
    end
    chk(rsp_valid_o, {tg, " response seen"}, 256'(rsp_valid_o), 1);
    if (!we && !inv) chk(rsp_rdata_o == erd, {tg, " load data"}, 256'(rsp_rdata_o), 256'(erd));
    if (ehit) chk(rd_cnt == rd0, {tg, " R4 no memory read on hit"}, 256'(rd_cnt - rd0), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int rd0;
    void'($urandom(32'd11));
    rst_ni = 0; req_valid_i = 0; req_write_i = 0; req_inval_i = 0;
    req_addr_i = '0; req_wdata_i = '0;
    mem_rd_ready_i = 0; mem_rdata_valid_i = 0; mem_rdata_i = '0; mem_wr_ready_i = 0;
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready_o && !rsp_valid_o && !mem_rd_valid_o && !mem_wr_valid_o,
        "R2 reset outputs", {req_ready_o, rsp_valid_o, mem_rd_valid_o, mem_wr_valid_o}, 4'b1000);
    rst_ni = 1;
    tick();

    // R2/R5: cold miss, then R3 hit
    rd0 = rd_cnt;
    do_req(0, 0, mk(1, 2, 0), 0, "R2 cold load miss", 0);
    chk(rd_cnt == rd0 + 1, "R5 one line read on miss", 256'(rd_cnt - rd0), 1);
    do_req(0, 0, mk(1, 2, 1), 0, "R3 load hit", 0);
    // R4: repeated store hits, no traffic
    do_req(1, 0, mk(1, 2, 2), 32'h1111, "R4 store hit", 0);
    do_req(1, 0, mk(1, 2, 2), 32'h2222, "R4 store hit again", 0);
    chk(!mem_wr_valid_o && wq_addr.size() == 0, "R4 no write traffic", 256'(mem_wr_valid_o), 0);
    do_req(0, 0, mk(1, 2, 2), 0, "R4 load after stores", 0);

    // R7 dirty victim queued, R9 forward from queue, R11 clean victim dropped
    wr_hold = 1;
    do_req(0, 0, mk(2, 2, 0), 0, "R7 conflict miss", 0);
    chk(mem_wr_valid_o && mem_wr_addr_o == 27'(1 * 64 + 2), "R7 dirty victim at queue head",
        256'(mem_wr_addr_o), 256'(66));
    rd0 = rd_cnt;
    do_req(0, 0, mk(1, 2, 2), 0, "R9 refill forwarded", 0);
    chk(rd_cnt == rd0, "R9 no memory read when queued", 256'(rd_cnt - rd0), 0);
    chk(wq_addr.size() == 1, "R11 clean victim not queued", 256'(wq_addr.size()), 1);
    wr_hold = 0;
    for (int i = 0; i < 200 && wq_addr.size() != 0; i++) tick();

    // R6 store misses allocate; R8 full queue stall
    for (int i = 0; i < 5; i++) do_req(1, 0, mk(3, 8 + i, 0), 32'h100 + i, "R6 store miss", 0);
    do_req(0, 0, mk(3, 8, 0), 0, "R6 merged word", 0);
    wr_hold = 1;
    for (int i = 0; i < 4; i++) do_req(1, 0, mk(4, 8 + i, 1), 32'h200 + i, "R8 fill queue", 0);
    chk(wq_addr.size() == 4, "R8 queue holds four", 256'(wq_addr.size()), 4);
    do_req(1, 0, mk(4, 12, 1), 32'h204, "R8 miss on full queue", 40);
    chk(released, "R8 stalled while full", 256'(released), 1);
    for (int i = 0; i < 300 && wq_addr.size() != 0; i++) tick();

    // R10 invalidate
    do_req(1, 0, mk(5, 20, 3), 32'hDEAD, "R10 dirty line", 0);
    do_req(0, 1, mk(6, 20, 0), 0, "R10 non-matching invalidate", 0);
    rd0 = rd_cnt;
    do_req(0, 0, mk(5, 20, 3), 0, "R10 line survives", 0);
    chk(rd_cnt == rd0, "R10 still hits", 256'(rd_cnt - rd0), 0);
    do_req(0, 1, mk(5, 20, 0), 0, "R10 matching invalidate", 0);
    chk(!mem_wr_valid_o && wq_addr.size() == 0, "R10 no write-back", 256'(mem_wr_valid_o), 0);
    rd0 = rd_cnt;
    do_req(0, 0, mk(5, 20, 3), 0, "R10 reload old data", 0);
    chk(rd_cnt == rd0 + 1, "R10 misses after invalidate", 256'(rd_cnt - rd0), 1);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 10);
      do_req(op >= 6, op == 0, mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 8)),
             $urandom, "R1 mixed", 0);
    end

    wr_hold = 0;
    for (int i = 0; i < 500 && wq_addr.size() != 0; i++) tick();
    repeat (3) tick();
    chk(wq_addr.size() == 0 && !mem_wr_valid_o, "R7 queue drained",
        256'(wq_addr.size()), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule